// File: doc/BRIEF.md
# Chained Command Buffer Fetch Engine

This block pulls 64-bit command words out of a queue that lives in memory as a chain of fixed-size segments. Each segment starts on a 128-byte boundary. The last word of every segment carries the address of the next segment, so a segment of S words holds S-1 commands. Software points the engine at the first segment through a configuration write. It then tells the engine how many command words are ready by writing increments to a doorbell counter. The engine issues memory reads for exactly that many commands, walks across segment boundaries on its own, and passes each returned command word to the consumer.

When the engine leaves a segment, it hands the old segment back on a free-request output. The request carries a free-list pool index and a don't-write-back count, both taken from the configuration. A throttle register caps how many data reads may be outstanding at once. A doorbell increment that would overflow the counter is discarded and sets a sticky error flag, which drives an interrupt when it is enabled by a mask bit.

The memory port is a valid/ready read request with in-order responses. A response's meaning follows from the engine's state: while a link read is pending, the response is the next-segment pointer; otherwise it is a command.

Top module: `cmd_chain_fetch`

## Requirements
- R1: A configuration write accepted while the doorbell count is zero restarts fetching at word 0 of the new base. The base is the pointer field times 128. Word k of a segment is read from base + 8*k, and commands come out on cmdData in ascending address order.
- R2: A segment of cfgSize words (cfgSize >= 2) holds cfgSize-1 commands. Its last word is the link word, and bits [39:7] of the link word become the next segment's pointer. Bits [63:40] and [6:0] of the link word are ignored.
- R3: After each link response, freeValid pulses for exactly one cycle. During that cycle freeAddr is the old segment base, and freePool and freeDwb carry the configured pool and don't-write-back values.
- R4: A doorbell write adds dbInc to the pending count, and each data read issued takes one from it. No read of any kind (data or link) is issued while the count is zero, so exactly as many commands are delivered as were rung.
- R5: A configuration write made while the doorbell count is nonzero is ignored, and fetching continues along the old chain.
- R6: Outstanding data reads never exceed min(throttle, 8). A throttle value above 8 acts as 8, and a value of 0 stops all new reads. The throttle is 8 after reset.
- R7: A link read is issued only when no data read is outstanding. No read is issued while the link response is pending.
- R8: A doorbell write whose sum would exceed the counter's maximum is discarded and the count is kept. The same write sets the error flag, which stays set.
- R9: An error-clear write with errClrBit = 1 clears the error flag; with errClrBit = 0 it has no effect.
- R10: irq equals the error flag AND the interrupt mask bit. The mask is 0 after reset.
- R11: After reset, no read request, command, free request, error or interrupt is asserted.
- R12: A read request held while rdReqReady is low keeps its address and stays asserted until it is accepted, unless the throttle is rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgPtr | input | 33 | Start pointer, address bits [39:7] |
| cfgSize | input | 13 | Segment size in 64-bit words |
| cfgPool | input | 3 | Free-list pool index |
| cfgDwb | input | 9 | Don't-write-back count for free requests |
| dbWe | input | 1 | Doorbell write strobe |
| dbInc | input | DB_W | Number of command words added |
| thrWe | input | 1 | Throttle write strobe |
| thrVal | input | 4 | Maximum outstanding data reads |
| errClrWe | input | 1 | Error-clear write strobe |
| errClrBit | input | 1 | Write 1 to clear the error flag |
| maskWe | input | 1 | Interrupt mask write strobe |
| maskVal | input | 1 | Interrupt mask value |
| rdReqValid | output | 1 | Read request valid |
| rdReqReady | input | 1 | Read request accepted |
| rdReqAddr | output | 40 | Read byte address |
| rdReqIsLink | output | 1 | Request is a link-word read |
| rdRspValid | input | 1 | Read response valid (in order) |
| rdRspData | input | 64 | Read response data |
| cmdValid | output | 1 | Command word valid |
| cmdData | output | 64 | Command word |
| freeValid | output | 1 | Free request for a used-up segment |
| freeAddr | output | 40 | Base address of the freed segment |
| freePool | output | 3 | Pool index of the free request |
| freeDwb | output | 9 | Don't-write-back count of the free request |
| errFlag | output | 1 | Sticky doorbell-overflow flag |
| irq | output | 1 | Masked interrupt |

## Verification
The situations hardest to reach from the ports are the ones where pending work has to sit unconsumed while something else happens. Two cases matter: a configuration rewrite with a nonzero doorbell, and a doorbell overflow whose effect on the count must be seen afterwards. The bench sets the throttle to 0 to freeze fetching, lines up the doorbell and the rewrite or overflowing write, then reopens the throttle and counts the commands and checks their addresses. The count is built with an 8-bit doorbell so that overflow takes only a few hundred commands to drain. Segment sizes and throttle limits are swept together, with a stalling ready pattern on alternate runs, against a memory with four-cycle latency.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic issueData;
    logic issueLink;
    logic takeLink;
  } ccfStrobes_t;
endpackage

// File: rtl/ccf_datapath.sv
module ccf_datapath
  import ccf_pkg::*;
#(
  parameter int ADDR_W  = 40,
  parameter int ALIGN_W = 7,
  parameter int SIZE_W  = 13,
  parameter int POOL_W  = 3,
  parameter int DWB_W   = 9,
  parameter int DATA_W  = 64
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ccfStrobes_t                 str,
  input  logic [ADDR_W-ALIGN_W-1:0]   cfgPtr,
  input  logic [SIZE_W-1:0]           cfgSize,
  input  logic [POOL_W-1:0]           cfgPool,
  input  logic [DWB_W-1:0]            cfgDwb,
  input  logic [ADDR_W-ALIGN_W-1:0]   linkPtr,
  output logic [ADDR_W-1:0]           reqAddr,
  output logic                        atLinkSlot,
  output logic                        freeValid,
  output logic [ADDR_W-1:0]           freeAddr,
  output logic [POOL_W-1:0]           freePool,
  output logic [DWB_W-1:0]            freeDwb
);
  localparam int PTR_W    = ADDR_W - ALIGN_W;
  localparam int WORD_SH  = $clog2(DATA_W / 8);

  logic [PTR_W-1:0]  basePtr;
  logic [SIZE_W-1:0] segSize;
  logic [SIZE_W-1:0] wordIdx;
  logic [POOL_W-1:0] poolReg;
  logic [DWB_W-1:0]  dwbReg;

  assign reqAddr    = ADDR_W'({basePtr, {ALIGN_W{1'b0}}}) + ADDR_W'({wordIdx, {WORD_SH{1'b0}}});
  assign atLinkSlot = (wordIdx == (segSize - SIZE_W'(1)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      basePtr   <= '0;
      segSize   <= SIZE_W'(2);
      wordIdx   <= '0;
      poolReg   <= '0;
      dwbReg    <= '0;
      freeValid <= 1'b0;
      freeAddr  <= '0;
      freePool  <= '0;
      freeDwb   <= '0;
    end else begin
      freeValid <= 1'b0;
      if (str.loadCfg) begin
        basePtr <= cfgPtr;
        segSize <= cfgSize;
        poolReg <= cfgPool;
        dwbReg  <= cfgDwb;
        wordIdx <= '0;
      end else if (str.takeLink) begin
        basePtr   <= linkPtr;
        wordIdx   <= '0;
        freeValid <= 1'b1;
        freeAddr  <= {basePtr, {ALIGN_W{1'b0}}};
        freePool  <= poolReg;
        freeDwb   <= dwbReg;
      end else if (str.issueData) begin
        wordIdx <= wordIdx + SIZE_W'(1);
      end
    end
  end

  // R2
  size_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.loadCfg |-> cfgSize >= SIZE_W'(2));
  // R3
  free_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    freeValid |=> !freeValid);
  // R1
  data_idx_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.issueData |-> !atLinkSlot);
endmodule

// File: rtl/ccf_ctrl.sv
module ccf_ctrl
  import ccf_pkg::*;
#(
  parameter int DB_W     = 16,
  parameter int THR_W    = 4,
  parameter int MAX_INFL = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic             dbWe,
  input  logic [DB_W-1:0]  dbInc,
  input  logic             thrWe,
  input  logic [THR_W-1:0] thrVal,
  input  logic             errClrWe,
  input  logic             errClrBit,
  input  logic             maskWe,
  input  logic             maskVal,
  input  logic             rdReqReady,
  input  logic             rdRspValid,
  input  logic             atLinkSlot,
  output logic             rdReqValid,
  output logic             rdReqIsLink,
  output logic             cmdValid,
  output logic             errFlag,
  output logic             irq,
  output ccfStrobes_t      str
);
  localparam int INF_W = $clog2(MAX_INFL + 1);

  typedef enum logic {stRun, stLink} ctrlState_t;

  ctrlState_t        state;
  logic [DB_W-1:0]   dbCnt;
  logic [THR_W-1:0]  thrReg;
  logic [INF_W-1:0]  inflight;
  logic [INF_W-1:0]  effLimit;
  logic              maskReg;
  logic              canIssue, fire, dataRsp, ovf;
  logic [DB_W:0]     sumWide;

  assign effLimit = (thrReg > THR_W'(MAX_INFL)) ? INF_W'(MAX_INFL) : INF_W'(thrReg);
  assign canIssue = (state == stRun) && (dbCnt != '0) && (effLimit != '0);
  assign rdReqValid  = canIssue && (atLinkSlot ? (inflight == '0) : (inflight < effLimit));
  assign rdReqIsLink = atLinkSlot;
  assign fire     = rdReqValid && rdReqReady;
  assign dataRsp  = rdRspValid && (state == stRun);
  assign cmdValid = dataRsp;

  always_comb begin
    str.loadCfg   = cfgWe && (dbCnt == '0) && (state == stRun);
    str.issueData = fire && !atLinkSlot;
    str.issueLink = fire && atLinkSlot;
    str.takeLink  = rdRspValid && (state == stLink);
  end

  assign sumWide = {1'b0, dbCnt} + (dbWe ? {1'b0, dbInc} : '0) - (DB_W + 1)'(str.issueData);
  assign ovf     = dbWe && sumWide[DB_W];
  assign irq     = errFlag && maskReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= stRun;
      dbCnt    <= '0;
      thrReg   <= THR_W'(MAX_INFL);
      inflight <= '0;
      errFlag  <= 1'b0;
      maskReg  <= 1'b0;
    end else begin
      if (str.issueLink)     state <= stLink;
      else if (str.takeLink) state <= stRun;
      inflight <= inflight + INF_W'(str.issueData) - INF_W'(dataRsp);
      dbCnt    <= ovf ? (dbCnt - DB_W'(str.issueData)) : sumWide[DB_W-1:0];
      if (thrWe)  thrReg  <= thrVal;
      if (maskWe) maskReg <= maskVal;
      errFlag <= ovf || (errFlag && !(errClrWe && errClrBit));
    end
  end

  // R4
  no_fetch_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dbCnt == '0) |-> !rdReqValid);
  // R6
  inflight_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReqValid && !rdReqIsLink) |-> (inflight < effLimit) && (effLimit <= INF_W'(MAX_INFL)));
  // R7
  link_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == stLink) |-> !rdReqValid && (inflight == '0));
  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(dbWe));
  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> errFlag);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReqValid && !rdReqReady && !thrWe) |=> rdReqValid && $stable(rdReqIsLink));
endmodule

// File: rtl/cmd_chain_fetch.sv
module cmd_chain_fetch
  import ccf_pkg::*;
#(
  parameter int ADDR_W   = 40,
  parameter int ALIGN_W  = 7,
  parameter int SIZE_W   = 13,
  parameter int POOL_W   = 3,
  parameter int DWB_W    = 9,
  parameter int DB_W     = 16,
  parameter int THR_W    = 4,
  parameter int MAX_INFL = 8,
  parameter int DATA_W   = 64
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWe,
  input  logic [ADDR_W-ALIGN_W-1:0] cfgPtr,
  input  logic [SIZE_W-1:0]         cfgSize,
  input  logic [POOL_W-1:0]         cfgPool,
  input  logic [DWB_W-1:0]          cfgDwb,
  input  logic                      dbWe,
  input  logic [DB_W-1:0]           dbInc,
  input  logic                      thrWe,
  input  logic [THR_W-1:0]          thrVal,
  input  logic                      errClrWe,
  input  logic                      errClrBit,
  input  logic                      maskWe,
  input  logic                      maskVal,
  output logic                      rdReqValid,
  input  logic                      rdReqReady,
  output logic [ADDR_W-1:0]         rdReqAddr,
  output logic                      rdReqIsLink,
  input  logic                      rdRspValid,
  input  logic [DATA_W-1:0]         rdRspData,
  output logic                      cmdValid,
  output logic [DATA_W-1:0]         cmdData,
  output logic                      freeValid,
  output logic [ADDR_W-1:0]         freeAddr,
  output logic [POOL_W-1:0]         freePool,
  output logic [DWB_W-1:0]          freeDwb,
  output logic                      errFlag,
  output logic                      irq
);
  ccfStrobes_t str;
  logic        atLinkSlot;

  assign cmdData = rdRspData;

  ccf_ctrl #(.DB_W(DB_W), .THR_W(THR_W), .MAX_INFL(MAX_INFL)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .dbWe(dbWe), .dbInc(dbInc),
    .thrWe(thrWe), .thrVal(thrVal), .errClrWe(errClrWe), .errClrBit(errClrBit),
    .maskWe(maskWe), .maskVal(maskVal), .rdReqReady(rdReqReady),
    .rdRspValid(rdRspValid), .atLinkSlot(atLinkSlot), .rdReqValid(rdReqValid),
    .rdReqIsLink(rdReqIsLink), .cmdValid(cmdValid), .errFlag(errFlag),
    .irq(irq), .str(str)
  );

  ccf_datapath #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W), .SIZE_W(SIZE_W),
                 .POOL_W(POOL_W), .DWB_W(DWB_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .str(str), .cfgPtr(cfgPtr), .cfgSize(cfgSize),
    .cfgPool(cfgPool), .cfgDwb(cfgDwb), .linkPtr(rdRspData[ADDR_W-1:ALIGN_W]),
    .reqAddr(rdReqAddr), .atLinkSlot(atLinkSlot), .freeValid(freeValid),
    .freeAddr(freeAddr), .freePool(freePool), .freeDwb(freeDwb)
  );
endmodule

// File: tb/tb_cmd_chain_fetch.sv
`timescale 1ns/1ps
module tb_cmd_chain_fetch;
  localparam int DB_W = 8;
  localparam int LAT  = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWe = 0, dbWe = 0, thrWe = 0, errClrWe = 0, errClrBit = 0, maskWe = 0, maskVal = 0;
  logic [32:0] cfgPtr = '0;
  logic [12:0] cfgSize = '0;
  logic [2:0]  cfgPool = '0;
  logic [8:0]  cfgDwb = '0;
  logic [DB_W-1:0] dbInc = '0;
  logic [3:0]  thrVal = '0;
  logic rdReqValid, rdReqReady, rdReqIsLink, rdRspValid, cmdValid, freeValid, errFlag, irq;
  logic [39:0] rdReqAddr, freeAddr;
  logic [63:0] rdRspData, cmdData;
  logic [2:0]  freePool;
  logic [8:0]  freeDwb;

  always #2.5 clk = ~clk;

  cmd_chain_fetch #(.DB_W(DB_W)) dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgPtr(cfgPtr), .cfgSize(cfgSize),
    .cfgPool(cfgPool), .cfgDwb(cfgDwb), .dbWe(dbWe), .dbInc(dbInc), .thrWe(thrWe),
    .thrVal(thrVal), .errClrWe(errClrWe), .errClrBit(errClrBit), .maskWe(maskWe),
    .maskVal(maskVal), .rdReqValid(rdReqValid), .rdReqReady(rdReqReady),
    .rdReqAddr(rdReqAddr), .rdReqIsLink(rdReqIsLink), .rdRspValid(rdRspValid),
    .rdRspData(rdRspData), .cmdValid(cmdValid), .cmdData(cmdData),
    .freeValid(freeValid), .freeAddr(freeAddr), .freePool(freePool),
    .freeDwb(freeDwb), .errFlag(errFlag), .irq(irq)
  );

  int errors = 0, checks = 0;
  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: fixed latency, in order; link word = next ptr (base+3) with junk bits
  logic [LAT-1:0] pV, pL;
  logic [63:0]    pD [LAT];
  int  occ;
  logic [31:0] cyc;
  bit  stallMode = 0;
  assign rdReqReady = stallMode ? (cyc[1:0] != 2'b11) : 1'b1;
  assign rdRspValid = pV[LAT-1];
  assign rdRspData  = pD[LAT-1];

  always @(posedge clk) begin
    if (!rstN) begin
      pV <= '0; pL <= '0; occ <= 0; cyc <= '0;
      for (int i = 0; i < LAT; i++) pD[i] <= '0;
    end else begin
      cyc <= cyc + 1;
      for (int i = LAT-1; i > 0; i--) begin
        pV[i] <= pV[i-1]; pL[i] <= pL[i-1]; pD[i] <= pD[i-1];
      end
      pV[0] <= rdReqValid && rdReqReady;
      pL[0] <= rdReqIsLink;
      pD[0] <= rdReqIsLink ? {24'hABCDEF, rdReqAddr[39:7] + 33'd3, 7'h5A}
                           : {24'hC3A5E1, rdReqAddr};
      occ <= occ + int'(rdReqValid && rdReqReady && !rdReqIsLink)
                 - int'(pV[LAT-1] && !pL[LAT-1]);
    end
  end

  // expectation state and monitor
  logic [32:0] expBase, freeBase;
  int expIdx, expS, cmdSeen, freeSeen, reqSeen, peak;
  logic [2:0] expPool;
  logic [8:0] expDwb;

  always @(negedge clk) begin
    if (rstN) begin
      if (occ > peak) peak = occ;
      if (rdReqValid) reqSeen++;
      if (cmdValid) begin
        logic [39:0] ea;
        ea = {expBase, 7'b0} + 40'(expIdx * 8);
        check(cmdData == {24'hC3A5E1, ea}, "R1/R2 command order", cmdData, {24'hC3A5E1, ea});
        cmdSeen++;
        expIdx++;
        if (expIdx == expS - 1) begin expIdx = 0; expBase = expBase + 33'd3; end
      end
      if (freeValid) begin
        check(freeAddr == {freeBase, 7'b0} && freePool == expPool && freeDwb == expDwb,
              "R3 free request", {freePool, freeDwb, freeAddr}, {expPool, expDwb, freeBase, 7'b0});
        freeSeen++;
        freeBase = freeBase + 33'd3;
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic wrThr(input logic [3:0] v);
    thrVal = v; thrWe = 1; tick(); thrWe = 0;
  endtask
  task automatic wrDb(input int n);
    dbInc = DB_W'(n); dbWe = 1; tick(); dbWe = 0;
  endtask
  task automatic wrCfg(input logic [32:0] p, input int s, input logic [2:0] pl, input logic [8:0] dw);
    cfgPtr = p; cfgSize = 13'(s); cfgPool = pl; cfgDwb = dw; cfgWe = 1; tick(); cfgWe = 0;
  endtask
  task automatic setExp(input logic [32:0] p, input int s, input logic [2:0] pl, input logic [8:0] dw);
    expBase = p; freeBase = p; expIdx = 0; expS = s; expPool = pl; expDwb = dw;
    cmdSeen = 0; freeSeen = 0; reqSeen = 0; peak = 0;
  endtask
  task automatic waitCmds(input int n);
    for (int i = 0; i < 4000 && cmdSeen < n; i++) tick();
    repeat (30) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    setExp('0, 2, 0, 0);
    repeat (3) tick();
    rstN = 1;
    tick();
    // R11 reset state
    check({rdReqValid, cmdValid, freeValid, errFlag, irq} == 5'b0, "R11 reset outputs",
          {rdReqValid, cmdValid, freeValid, errFlag, irq}, 0);

    // sweep segment sizes x throttle values (R1 R2 R3 R4 R6 R7)
    for (int si = 0; si < 4; si++) begin
      for (int ti = 0; ti < 4; ti++) begin
        int s, thr, n, lim, k;
        logic [32:0] b;
        s   = (si == 0) ? 2 : (si == 1) ? 3 : (si == 2) ? 5 : 8;
        thr = (ti == 0) ? 1 : (ti == 1) ? 2 : (ti == 2) ? 8 : 12;
        k   = si * 4 + ti;
        n   = 2 * (s - 1) + 1;
        lim = (thr > 8) ? 8 : thr;
        b   = 33'h100 + 33'(k * 64);
        stallMode = k[0];
        wrThr(4'(thr));
        wrCfg(b, s, 3'(k), 9'(k * 37));
        setExp(b, s, 3'(k), 9'(k * 37));
        wrDb(n);
        waitCmds(n);
        check(cmdSeen == n, "R4 delivered count equals doorbell", 64'(cmdSeen), 64'(n));
        check(freeSeen == (n - 1) / (s - 1), "R3 free count", 64'(freeSeen), 64'((n - 1) / (s - 1)));
        check(peak <= lim && peak >= 1, "R6 in-flight cap", 64'(peak), 64'(lim));
      end
    end
    stallMode = 0;

    // throttle 0 pauses; config rewrite with pending count is ignored (R5 R6)
    wrThr(4'd0);
    wrCfg(33'h2000, 3, 3'd6, 9'h155);
    setExp(33'h2000, 3, 3'd6, 9'h155);
    wrDb(4);
    repeat (40) tick();
    check(reqSeen == 0, "R6 throttle zero pauses fetch", 64'(reqSeen), 0);
    wrCfg(33'h3000, 5, 3'd1, 9'h0AA);
    wrThr(4'd3);
    waitCmds(4);
    check(cmdSeen == 4, "R5 old chain kept after ignored rewrite", 64'(cmdSeen), 4);
    check(freeSeen == 1, "R5 free from old chain", 64'(freeSeen), 1);

    // overflow: add discarded, sticky flag, mask, W1C (R8 R9 R10)
    wrThr(4'd0);
    wrCfg(33'h4000, 5, 3'd2, 9'h011);
    setExp(33'h4000, 5, 3'd2, 9'h011);
    wrDb(200);
    tick();
    check(errFlag == 1'b0, "R8 no error below max", 64'(errFlag), 0);
    wrDb(100);
    tick();
    check(errFlag == 1'b1, "R8 overflow sets flag", 64'(errFlag), 1);
    check(irq == 1'b0, "R10 irq masked", 64'(irq), 0);
    maskVal = 1; maskWe = 1; tick(); maskWe = 0;
    tick();
    check(irq == 1'b1, "R10 irq enabled", 64'(irq), 1);
    errClrBit = 0; errClrWe = 1; tick(); errClrWe = 0;
    tick();
    check(errFlag == 1'b1, "R9 clear with zero ignored", 64'(errFlag), 1);
    wrThr(4'd8);
    waitCmds(200);
    check(cmdSeen == 200, "R8 overflowing add discarded", 64'(cmdSeen), 200);
    check(errFlag == 1'b1, "R8 flag sticky", 64'(errFlag), 1);
    errClrBit = 1; errClrWe = 1; tick(); errClrWe = 0;
    tick();
    check(errFlag == 1'b0, "R9 clear with one", 64'(errFlag), 0);
    check(irq == 1'b0, "R10 irq follows flag", 64'(irq), 0);

    // R1 fresh config after idle
    wrCfg(33'h5000, 4, 3'd7, 9'h1FF);
    setExp(33'h5000, 4, 3'd7, 9'h1FF);
    wrDb(7);
    waitCmds(7);
    check(cmdSeen == 7 && freeSeen == 2, "R1 new base after idle rewrite",
          64'({cmdSeen[15:0], freeSeen[15:0]}), 64'({16'd7, 16'd2}));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule